// File: doc/BRIEF.md
# Sequential Buffer Address Pointer

This block produces the word address for the clocked port of a buffer memory. The address is a pointer register that, on each rising clock edge, can step forward by one, take a value taken from the data bus one cycle earlier, or jump to one of two programmed buffer start addresses. A host-side register port writes the two start addresses and the two end addresses, and clears the flags.

Two comparators watch the pointer. When an increment lands the pointer on the end address of buffer 1 or buffer 2, the matching active-low end-of-buffer flag drops and stays low until the host clears it or the block is reset. Only the low `AW` bits of the sequential data bus connect to `load_addr`. A start strobe during a load, or in the cycle after one, breaks the port's usage rules, and the block reports this on `proto_err`.

Top module: `seq_buf_pointer`

## Requirements
- R1: While `rst_n` is low, with or without a clock edge, `ptr` is 0, `eob1_n` and `eob2_n` are 1, and all four start and end registers are 0.
- R2: On a rising edge where `cnt_en_n` is 0, `load` has no effect pending and both start strobes are 1, `ptr` becomes `ptr`+1, and 2^AW-1 wraps to 0.
- R3: On an edge where `load_n` is 0, `load_addr` is captured. `ptr` takes that value on the next edge and does not change because of the load on the capturing edge. On that next edge the pending load overrides the start strobes and the increment.
- R4: With no load pending, `strt1_n`=0 loads start register 1 into `ptr` and `strt2_n`=0 loads start register 2. Start 1 wins over start 2, and both win over the increment.
- R5: When `cfg_we`=1, `cfg_sel` picks the register that takes `cfg_wdata` on the edge: 0 is start 1, 1 is end 1, 2 is start 2, 3 is end 2, and 5 is control.
- R6: When an increment (R2) lands `ptr` on end register 1, `eob1_n` goes to 0 after that edge. End register 2 drives `eob2_n` the same way. The two comparisons are independent.
- R7: A low flag stays low until a control write with bit 0 = 0 (for `eob1_n`) or bit 1 = 0 (for `eob2_n`). A 1 in that bit leaves the flag as it is. If a set and a clear arrive on the same edge, the set wins.
- R8: A load (R3) or a start jump (R4) that lands on an end address does not change that flag.
- R9: `proto_err` is 1 while a start strobe is 0 and either `load_n` is 0 or a load captured on the previous edge is pending. Otherwise it is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cnt_en_n | input | 1 | Active-low increment enable |
| load_n | input | 1 | Active-low delayed load strobe |
| strt1_n | input | 1 | Active-low jump to start register 1 |
| strt2_n | input | 1 | Active-low jump to start register 2 |
| load_addr | input | AW | Low bits of the sequential data bus, used as the load value |
| cfg_we | input | 1 | Host register write enable |
| cfg_sel | input | SW | Host register select |
| cfg_wdata | input | AW | Host write data |
| ptr | output | AW | Current pointer |
| eob1_n | output | 1 | Active-low end-of-buffer flag 1 |
| eob2_n | output | 1 | Active-low end-of-buffer flag 2 |
| proto_err | output | 1 | Start strobe during or just after a load |

## Verification
The bench builds the block with `AW` = 4, so the pointer covers 16 addresses. The increment sweep therefore passes the wrap several times. Every possible end address is tried for both comparators, and every start and load value is written and jumped to. This small address space makes it possible to check each flag set, hold and clear, the set-versus-clear collision, and the no-flag-on-jump rule at every address instead of a few samples.

// File: rtl/seq_buf_pointer.sv
module seq_buf_pointer #(
  parameter int AW = 12,
  parameter int SW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cnt_en_n,
  input  logic          load_n,
  input  logic          strt1_n,
  input  logic          strt2_n,
  input  logic [AW-1:0] load_addr,
  input  logic          cfg_we,
  input  logic [SW-1:0] cfg_sel,
  input  logic [AW-1:0] cfg_wdata,
  output logic [AW-1:0] ptr,
  output logic          eob1_n,
  output logic          eob2_n,
  output logic          proto_err
);
  localparam int NBUF     = 2;
  localparam int SEL_CTRL = 5;

  logic [AW-1:0] start_q [NBUF];
  logic [AW-1:0] end_q   [NBUF];
  logic [NBUF-1:0] flag_q, hit, clr;
  logic [AW-1:0] ld_val;
  logic ld_pend;
  logic [AW-1:0] ptr_inc;
  logic inc_en;
  logic ctrl_wr;

  assign ptr_inc = ptr + 1'b1;
  assign inc_en  = !ld_pend && strt1_n && strt2_n && !cnt_en_n;
  assign ctrl_wr = cfg_we && (cfg_sel == SW'(SEL_CTRL));

  genvar b;
  generate
    for (b = 0; b < NBUF; b++) begin : g_cmp
      assign hit[b] = inc_en && (ptr_inc == end_q[b]);
      assign clr[b] = ctrl_wr && !cfg_wdata[b];
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NBUF; i++) begin
        start_q[i] <= '0;
        end_q[i]   <= '0;
      end
    end else if (cfg_we) begin
      for (int i = 0; i < NBUF; i++) begin
        if (cfg_sel == SW'(2 * i))     start_q[i] <= cfg_wdata;
        if (cfg_sel == SW'(2 * i + 1)) end_q[i]   <= cfg_wdata;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ld_pend <= 1'b0;
      ld_val  <= '0;
    end else begin
      ld_pend <= !load_n;
      if (!load_n) ld_val <= load_addr;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          ptr <= '0;
    else if (ld_pend)    ptr <= ld_val;
    else if (!strt1_n)   ptr <= start_q[0];
    else if (!strt2_n)   ptr <= start_q[1];
    else if (!cnt_en_n)  ptr <= ptr_inc;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag_q <= '0;
    else begin
      for (int i = 0; i < NBUF; i++) begin
        if (hit[i])      flag_q[i] <= 1'b1;
        else if (clr[i]) flag_q[i] <= 1'b0;
      end
    end
  end

  assign eob1_n    = !flag_q[0];
  assign eob2_n    = !flag_q[1];
  assign proto_err = (!strt1_n || !strt2_n) && (!load_n || ld_pend);

endmodule

module seq_buf_pointer_chk #(
  parameter int AW = 12,
  parameter int SW = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cnt_en_n,
  input logic          load_n,
  input logic          strt1_n,
  input logic          strt2_n,
  input logic [AW-1:0] load_addr,
  input logic          cfg_we,
  input logic [SW-1:0] cfg_sel,
  input logic [AW-1:0] cfg_wdata,
  input logic [AW-1:0] ptr,
  input logic          eob1_n,
  input logic          eob2_n,
  input logic          proto_err,
  input logic          ld_pend,
  input logic [AW-1:0] ld_val,
  input logic [AW-1:0] start1,
  input logic [AW-1:0] end1
);
  a_r1_reset_state: assert property (@(posedge clk)
    !rst_n |-> (ptr == '0 && eob1_n && eob2_n));

  a_r2_step: assert property (@(posedge clk) disable iff (!rst_n)
    (!cnt_en_n && !ld_pend && strt1_n && strt2_n) |=> (ptr == AW'($past(ptr) + 1'b1)));

  a_r3_capture: assert property (@(posedge clk) disable iff (!rst_n)
    !load_n |=> (ld_pend && ld_val == $past(load_addr)));

  a_r3_apply: assert property (@(posedge clk) disable iff (!rst_n)
    ld_pend |=> (ptr == $past(ld_val)));

  a_r4_start1: assert property (@(posedge clk) disable iff (!rst_n)
    (!ld_pend && !strt1_n) |=> (ptr == $past(start1)));

  a_r6_r8_set_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(eob1_n) |-> (ptr == end1 && $past(!cnt_en_n && !ld_pend && strt1_n && strt2_n)));

  a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!eob1_n && !(cfg_we && cfg_sel == SW'(5) && !cfg_wdata[0])) |=> !eob1_n);

  a_r9_violation: assert property (@(posedge clk) disable iff (!rst_n)
    ((!strt1_n || !strt2_n) && (!load_n || ld_pend)) |-> proto_err);

  a_r9_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (strt1_n && strt2_n && !eob2_n) |-> !proto_err);
endmodule

bind seq_buf_pointer seq_buf_pointer_chk #(.AW(AW), .SW(SW)) u_chk (
  .clk(clk), .rst_n(rst_n), .cnt_en_n(cnt_en_n), .load_n(load_n),
  .strt1_n(strt1_n), .strt2_n(strt2_n), .load_addr(load_addr),
  .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
  .ptr(ptr), .eob1_n(eob1_n), .eob2_n(eob2_n), .proto_err(proto_err),
  .ld_pend(ld_pend), .ld_val(ld_val), .start1(start_q[0]), .end1(end_q[0])
);

// File: tb/seq_buf_pointer_bench.sv
module seq_buf_pointer_bench;
  localparam int AW = 4;
  localparam int SW = 3;
  localparam int DEPTH = 1 << AW;
  localparam int MASK = DEPTH - 1;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst_n, cnt_en_n, load_n, strt1_n, strt2_n, cfg_we;
  logic [AW-1:0] load_addr, cfg_wdata, ptr;
  logic [SW-1:0] cfg_sel;
  logic eob1_n, eob2_n, proto_err;

  seq_buf_pointer #(.AW(AW), .SW(SW)) u_seq_buf_pointer (
    .clk(clk), .rst_n(rst_n), .cnt_en_n(cnt_en_n), .load_n(load_n),
    .strt1_n(strt1_n), .strt2_n(strt2_n), .load_addr(load_addr),
    .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
    .ptr(ptr), .eob1_n(eob1_n), .eob2_n(eob2_n), .proto_err(proto_err)
  );

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic drive(bit cnt, bit ld, bit s1, bit s2, int d, bit we, int sel, int wv);
    @(negedge clk);
    cnt_en_n = !cnt; load_n = !ld; strt1_n = !s1; strt2_n = !s2;
    load_addr = AW'(d); cfg_we = we; cfg_sel = SW'(sel); cfg_wdata = AW'(wv);
    @(posedge clk);
    #1;
  endtask

  task automatic idle();         drive(0, 0, 0, 0, 0, 0, 0, 0); endtask
  task automatic step();         drive(1, 0, 0, 0, 0, 0, 0, 0); endtask
  task automatic wr(int sel, int v); drive(0, 0, 0, 0, 0, 1, sel, v); endtask
  task automatic jump_to(int v); drive(0, 1, 0, 0, v, 0, 0, 0); idle(); endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    int exp;
    rst_n = 1'b0; cnt_en_n = 1'b1; load_n = 1'b1; strt1_n = 1'b1; strt2_n = 1'b1;
    cfg_we = 1'b0; cfg_sel = '0; cfg_wdata = '0; load_addr = '0;
    repeat (3) @(posedge clk);
    #1;
    check("R1 ptr", ptr, 0);
    check("R1 eob1", eob1_n, 1);
    check("R1 eob2", eob2_n, 1);
    check("R9 idle", proto_err, 0);
    @(negedge clk) rst_n = 1'b1;

    // R2 sweep with wrap; end registers reset to 0 so landing on 0 sets both (R6)
    for (int i = 1; i <= 40; i++) begin
      step();
      check("R2 inc", ptr, i % DEPTH);
      check("R6 eob1 at 0", eob1_n, (i >= DEPTH) ? 0 : 1);
      check("R6 eob2 at 0", eob2_n, (i >= DEPTH) ? 0 : 1);
    end
    wr(5, 0);
    check("R7 clear1", eob1_n, 1);
    check("R7 clear2", eob2_n, 1);

    // R3 delayed load, with and without a concurrent increment
    exp = ptr;
    for (int v = 0; v < DEPTH; v++) begin
      bit c = v[0];
      drive(c, 1, 0, 0, v, 0, 0, 0);
      exp = c ? (exp + 1) & MASK : exp;
      check("R3 no change on capture", ptr, exp);
      drive(c, 0, 0, 0, 0, 0, 0, 0);
      exp = v;
      check("R3 applied next edge", ptr, exp);
    end

    // R4/R5 start registers
    for (int s = 0; s < DEPTH; s++) begin
      wr(0, s);
      wr(2, MASK - s);
      drive(1, 0, 1, 0, 0, 0, 0, 0);
      check("R4 start1 over inc", ptr, s);
      drive(1, 0, 0, 1, 0, 0, 0, 0);
      check("R4 start2 over inc", ptr, MASK - s);
      drive(0, 0, 1, 1, 0, 0, 0, 0);
      check("R4 start1 over start2", ptr, s);
    end

    // R6/R7/R8 end comparators at every address
    for (int k = 0; k < DEPTH; k++) begin
      int k2;
      k2 = (k + 7) & MASK;
      wr(1, k);
      wr(3, k2);
      wr(5, 0);
      jump_to((k - 2) & MASK);
      check("R8 load clear", eob1_n, 1);
      step();
      check("R6 before end1", eob1_n, 1);
      step();
      check("R5 R6 end1 hit", eob1_n, 0);
      check("R6 end2 independent", eob2_n, 1);
      for (int j = 1; j <= 7; j++) begin
        step();
        check("R7 eob1 sticky", eob1_n, 0);
        check("R6 end2", eob2_n, (j == 7) ? 0 : 1);
      end
      wr(5, 2);
      check("R7 clear bit0", eob1_n, 1);
      check("R7 bit1 one keeps", eob2_n, 0);
      wr(5, 1);
      check("R7 clear bit1", eob2_n, 1);
      check("R7 bit0 one keeps", eob1_n, 1);
      jump_to(k);
      check("R8 load onto end1", eob1_n, 1);
      wr(0, k2);
      drive(0, 0, 1, 0, 0, 0, 0, 0);
      check("R8 start onto end2 ptr", ptr, k2);
      check("R8 start onto end2", eob2_n, 1);
      jump_to((k - 1) & MASK);
      drive(1, 0, 0, 0, 0, 1, 5, 0);
      check("R7 set wins over clear", eob1_n, 0);
      wr(5, 0);
    end

    // R9 protocol violation
    @(negedge clk);
    cnt_en_n = 1; load_n = 0; strt1_n = 1; strt2_n = 1; cfg_we = 0; load_addr = 4'd3;
    #1 check("R9 load only", proto_err, 0);
    strt1_n = 0;
    #1 check("R9 start during load", proto_err, 1);
    @(posedge clk);
    @(negedge clk);
    load_n = 1; strt1_n = 1; strt2_n = 0;
    #1 check("R9 start after load", proto_err, 1);
    @(posedge clk);
    #1 check("R3 load wins over start", ptr, 3);
    @(negedge clk);
    #1 check("R9 start no load", proto_err, 0);
    idle();

    // R1 asynchronous reset clears registers
    wr(0, 11);
    jump_to(6);
    @(negedge clk);
    #2 rst_n = 1'b0;
    #1 check("R1 async ptr", ptr, 0);
    @(negedge clk) rst_n = 1'b1;
    drive(0, 0, 1, 0, 0, 0, 0, 0);
    check("R1 start1 reset", ptr, 0);
    idle();

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule